// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is a synchronous serial master that runs one conversion-and-readback frame against a 12-bit multi-input ADC with a serial output. When it is idle, a start request latches an 8-bit command. The controller then raises chip select for a programmable number of cycles and drops it again. Next it produces 16 serial clocks while chip select stays low. During those clocks it sends the command twice, once in each byte slot, and collects the 16 bits that the converter returns.

Data returned during a frame belongs to the conversion that the previous frame requested. Bit 1 of the command tells the controller how to read what comes back. With the bit clear, the first byte is the high byte and bits arrive most significant first. With the bit set, the first byte is the low byte, and the controller bit-reverses both bytes before it packs them. At the end of the frame, a one-cycle done strobe comes out together with the normalised 16-bit word. The controller then waits out a programmable conversion time before it will take another start. The serial clock rate, the chip-select pulse length and the conversion wait are all parameters counted in system-clock cycles.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: During and after synchronous reset, the serial clock, chip select, busy and done outputs are low and the result is zero.
- R2: A start request seen while idle raises chip select (`adc_cs_o`, high means deselected) for exactly CS_HIGH_CYC cycles. Chip select then goes low and stays low for the whole frame.
- R3: A frame has exactly 16 rising serial-clock edges, and every one occurs while chip select is low. Each high phase of the serial clock lasts HALF_PER system cycles.
- R4: The latched command is sent most significant bit first in both byte slots, so the converter collects the same byte twice. Each command bit is set up after a falling edge and is stable across the next rising edge.
- R5: With command bit 1 clear, the returned bits are sampled on falling serial-clock edges. The first bit received lands in result bit 15 and the sixteenth in bit 0.
- R6: With command bit 1 set, the first byte received becomes result bits [7:0] and the second becomes bits [15:8]. Each byte is bit-reversed, so the first bit received lands in result bit 0 and the sixteenth in bit 15.
- R7: Done is high for exactly one cycle per frame, and the result is valid in that cycle. The result then holds until the next done.
- R8: Busy is high from the cycle after an accepted start through the done cycle. It then stays high for CONV_WAIT_CYC cycles counted from and including the done cycle.
- R9: A start request while busy is ignored. It does not change the command being sent and starts no extra frame.
- R10: The serial clock is low whenever chip select is high and whenever the block is idle or waiting for conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one frame (taken only while idle) |
| cmd_i | input | 8 | Command byte: [7:4] input select, bit 1 LSB-first flag |
| adc_dout_i | input | 1 | Serial data returned by the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter, idles low |
| adc_din_o | output | 1 | Serial command bit to the converter |
| adc_cs_o | output | 1 | Chip select, high means deselected |
| busy_o | output | 1 | Frame or conversion wait in progress |
| done_o | output | 1 | One-cycle strobe, result valid |
| result_o | output | 16 | Normalised 16-bit readback |

## Verification
Two situations put a start request in the same cycle as something else. A request can arrive in the done cycle, while the conversion wait is still pending. A request can also arrive in the very first idle cycle after that wait ends. The bench drives start during the done strobe and also in the middle of a frame with an inverted command. It then checks that chip select stays low, that busy stays low, and that the converter model still collected the original command twice. It also holds start high across an entire frame and requires busy to drop for exactly one sample before the next frame begins.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // Position of the order flag inside the command byte
    localparam int ORDER_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CSHI  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_CONV  = 2'd3
    } seq_state_e;

    // Received stream split into arrival order
    typedef struct packed {
        logic [7:0] first;
        logic [7:0] second;
    } rx_pair_t;

    function automatic logic [7:0] bitrev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = v[7-i];
        end
        return r;
    endfunction

    function automatic logic [15:0] assemble_result(input logic [15:0] raw,
                                                    input logic      lsb_first);
        rx_pair_t p;
        p = raw;
        if (lsb_first) begin
            return {bitrev8(p.second), bitrev8(p.first)};
        end
        return {p.first, p.second};
    endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
    parameter int HALF_PER = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic sclk_o,
    output logic fall_o
);
    localparam int CW = $clog2(HALF_PER + 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          half_end;

    assign half_end = (cnt_q == CW'(HALF_PER - 1));
    assign fall_o   = en_i && sclk_q && half_end;
    assign sclk_o   = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (half_end) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    // R3: a high phase always lasts at least one full cycle before falling
    a_r3_fall_after_high: assert property (@(posedge clk) disable iff (rst)
        fall_o |-> $past(sclk_q));

endmodule

// File: rtl/sadc_shift_unit.sv
module sadc_shift_unit
    import sadc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en_i,
    input  logic        fall_i,
    input  logic        dout_i,
    input  logic [7:0]  cmd_i,
    output logic        din_o,
    output logic        frame_end_o,
    output logic        done_o,
    output logic [15:0] result_o
);
    logic [3:0]  bit_q;
    logic [15:0] rx_q;
    logic [15:0] rx_next;
    logic        done_q;
    logic [15:0] result_q;

    // Command bit index 7-n within the current byte slot
    assign din_o       = cmd_i[~bit_q[2:0]];
    assign frame_end_o = fall_i && (bit_q == 4'd15);
    assign rx_next     = {rx_q[14:0], dout_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q    <= '0;
            rx_q     <= '0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!en_i) begin
                bit_q <= '0;
            end else if (fall_i) begin
                bit_q <= bit_q + 4'd1;
                rx_q  <= rx_next;
                if (bit_q == 4'd15) begin
                    done_q   <= 1'b1;
                    result_q <= assemble_result(rx_next, cmd_i[ORDER_BIT]);
                end
            end
        end
    end

    assign done_o   = done_q;
    assign result_o = result_q;

    // R7: done never lasts two cycles
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7: result only moves together with a done strobe
    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(result_q));

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int CS_HIGH_CYC   = 4,
    parameter int CONV_WAIT_CYC = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] cmd_i,
    input  logic       frame_end_i,
    output seq_state_e state_o,
    output logic [7:0] cmd_o
);
    localparam int CNT_MAX = (CS_HIGH_CYC > CONV_WAIT_CYC) ? CS_HIGH_CYC : CONV_WAIT_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [7:0]    cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) begin
                        cmd_q   <= cmd_i;
                        state_q <= ST_CSHI;
                    end
                end
                ST_CSHI: begin
                    if (cnt_q == CW'(CS_HIGH_CYC - 1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_SHIFT;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_SHIFT: begin
                    cnt_q <= '0;
                    if (frame_end_i) begin
                        state_q <= ST_CONV;
                    end
                end
                default: begin
                    if (cnt_q == CW'(CONV_WAIT_CYC - 1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign cmd_o   = cmd_q;

    // R9: command is frozen while a frame or wait is running
    a_r9_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(cmd_q));

    // R2: the select pulse is only entered from idle
    a_r2_cshi_from_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CSHI) && ($past(state_q) != ST_CSHI) |-> $past(state_q) == ST_IDLE);

endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int HALF_PER      = 2,
    parameter int CS_HIGH_CYC   = 4,
    parameter int CONV_WAIT_CYC = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [7:0]  cmd_i,
    input  logic        adc_dout_i,
    output logic        adc_sclk_o,
    output logic        adc_din_o,
    output logic        adc_cs_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] result_o
);
    seq_state_e state;
    logic [7:0] cmd_lat;
    logic       shift_en;
    logic       sclk_fall;
    logic       frame_end;

    sadc_seq #(
        .CS_HIGH_CYC  (CS_HIGH_CYC),
        .CONV_WAIT_CYC(CONV_WAIT_CYC)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmd_i      (cmd_i),
        .frame_end_i(frame_end),
        .state_o    (state),
        .cmd_o      (cmd_lat)
    );

    assign shift_en = (state == ST_SHIFT);
    assign adc_cs_o = (state == ST_CSHI);
    assign busy_o   = (state != ST_IDLE);

    sadc_sclk_gen #(
        .HALF_PER(HALF_PER)
    ) sclk_i (
        .clk   (clk),
        .rst   (rst),
        .en_i  (shift_en),
        .sclk_o(adc_sclk_o),
        .fall_o(sclk_fall)
    );

    sadc_shift_unit shift_i (
        .clk        (clk),
        .rst        (rst),
        .en_i       (shift_en),
        .fall_i     (sclk_fall),
        .dout_i     (adc_dout_i),
        .cmd_i      (cmd_lat),
        .din_o      (adc_din_o),
        .frame_end_o(frame_end),
        .done_o     (done_o),
        .result_o   (result_o)
    );

    // R10: no serial clock while deselected or outside the shift phase
    a_r10_sclk_low_cs: assert property (@(posedge clk) disable iff (rst)
        (adc_cs_o || !busy_o) |-> !adc_sclk_o);

    // R3: rising edges only while selected and busy
    a_r3_rise_selected: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sclk_o) |-> (!adc_cs_o && busy_o));

    // R4: command bit does not move across a rising edge
    a_r4_din_stable: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sclk_o) |-> $stable(adc_din_o));

    // R8: done falls inside the busy window
    a_r8_done_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    // R2: chip select rises only out of idle
    a_r2_cs_rise_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_o) |-> !$past(busy_o));

endmodule

// File: tb/sadc_frame_ctrl_tb_top.sv
module sadc_frame_ctrl_tb_top;
    localparam int HALF = 2;
    localparam int CSH  = 4;
    localparam int WAIT = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [7:0]  cmd_i;
    logic        adc_dout_i;
    logic        adc_sclk_o;
    logic        adc_din_o;
    logic        adc_cs_o;
    logic        busy_o;
    logic        done_o;
    logic [15:0] result_o;

    int total = 0;
    int bad   = 0;

    // converter model state
    logic [15:0] raw_word = '0;
    logic [15:0] dev_cap  = '0;
    int          dev_n    = 0;

    always #2 clk = !clk;

    sadc_frame_ctrl #(
        .HALF_PER     (HALF),
        .CS_HIGH_CYC  (CSH),
        .CONV_WAIT_CYC(WAIT)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cmd_i     (cmd_i),
        .adc_dout_i(adc_dout_i),
        .adc_sclk_o(adc_sclk_o),
        .adc_din_o (adc_din_o),
        .adc_cs_o  (adc_cs_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    initial adc_dout_i = 1'b0;

    always @(posedge adc_cs_o) begin
        dev_n   = 0;
        dev_cap = '0;
    end

    always @(posedge adc_sclk_o) begin
        if (!adc_cs_o) begin
            dev_cap = {dev_cap[14:0], adc_din_o};
            if (dev_n < 16) adc_dout_i = raw_word[15 - dev_n];
            dev_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_result(input logic [15:0] raw, input logic lsbf);
        logic [15:0] r;
        if (!lsbf) return raw;
        for (int i = 0; i < 16; i++) r[i] = raw[15 - i];
        return r;
    endfunction

    task automatic run_frame(input logic [7:0] c, input logic [15:0] raw, input bit poke);
        int hi_n, rises, hrun, bz, guard;
        bit bad_half, idle_bad;
        logic ps;
        logic [15:0] exp;
        raw_word = raw;
        cmd_i    = c;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        hi_n = 0;
        idle_bad = 1'b0;
        while (adc_cs_o && hi_n < 1000) begin
            if (adc_sclk_o) idle_bad = 1'b1;
            hi_n++;
            @(negedge clk);
        end
        chk(hi_n == CSH, "R2 cs high length", hi_n, CSH);
        chk(!idle_bad, "R10 sclk low under cs", idle_bad, 0);
        rises = 0; hrun = 0; bad_half = 1'b0; ps = 1'b0; guard = 0;
        while (!done_o && guard < 10000) begin
            if (adc_sclk_o && !ps) rises++;
            if (adc_sclk_o) hrun++;
            else begin
                if (ps && hrun != HALF) bad_half = 1'b1;
                hrun = 0;
            end
            if (adc_cs_o) rises = rises + 100;
            if (poke && guard == 5) begin
                start_i = 1'b1;
                cmd_i   = ~c;
            end else if (poke && guard == 6) begin
                start_i = 1'b0;
                cmd_i   = c;
            end
            ps = adc_sclk_o;
            guard++;
            @(negedge clk);
        end
        if (ps && hrun != HALF) bad_half = 1'b1;
        if (poke) start_i = 1'b1;   // start during the done cycle
        exp = exp_result(raw, c[1]);
        chk(done_o == 1'b1, "R7 done seen", done_o, 1);
        chk(rises == 16, "R3 rising edge count", rises, 16);
        chk(!bad_half, "R3 high phase length", bad_half, 0);
        chk(dev_cap == {c, c}, "R4 command twice", dev_cap, {c, c});
        chk(result_o == exp, c[1] ? "R6 lsb-first result" : "R5 msb-first result",
            result_o, exp);
        bz = 1;
        idle_bad = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
        while (busy_o && bz < 1000) begin
            if (adc_cs_o || adc_sclk_o) idle_bad = 1'b1;
            bz++;
            @(negedge clk);
        end
        chk(bz == WAIT, "R8 conversion wait", bz, WAIT);
        chk(!idle_bad, "R10 quiet during wait", idle_bad, 0);
        chk(result_o == exp, "R7 result holds", result_o, exp);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                chk(!busy_o && !adc_cs_o, "R9 start while busy ignored", busy_o, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        int low_n;
        seed    = $urandom(32'd4711);
        rst     = 1'b1;
        start_i = 1'b0;
        cmd_i   = '0;
        repeat (3) @(negedge clk);
        chk(!adc_sclk_o && !adc_cs_o && !busy_o && !done_o && result_o == 0,
            "R1 reset state", {adc_sclk_o, adc_cs_o, busy_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!adc_sclk_o && !adc_cs_o && !busy_o && !done_o, "R1 after reset",
            {adc_sclk_o, adc_cs_o, busy_o, done_o}, 0);

        // directed corners
        run_frame(8'h50, 16'hA5C3, 1'b0);
        run_frame(8'h52, 16'hA5C3, 1'b0);
        run_frame(8'hFF, 16'h0001, 1'b1);
        run_frame(8'h00, 16'h8000, 1'b1);
        run_frame(8'hB2, 16'hFFFF, 1'b0);

        // random mix
        for (int n = 0; n < 24; n++) begin
            run_frame(8'($urandom), 16'($urandom), 1'($urandom));
        end

        // start held high: back-to-back frames, single idle sample between
        raw_word = 16'h3C5A;
        cmd_i    = 8'h42;
        start_i  = 1'b1;
        while (!done_o) @(negedge clk);
        chk(result_o == exp_result(16'h3C5A, 1'b1), "R6 held-start frame",
            result_o, exp_result(16'h3C5A, 1'b1));
        while (busy_o) @(negedge clk);
        low_n = 0;
        while (!busy_o && low_n < 100) begin
            low_n++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(low_n == 1, "R9 first idle cycle accepts start", low_n, 1);
        while (!done_o) @(negedge clk);
        chk(dev_cap == 16'h4242, "R4 second held frame command", dev_cap, 16'h4242);
        while (busy_o) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule